// File: doc/BRIEF.md
# Shared-Clock Two-Port Memory with Per-Port Write Behaviour

This block is a synchronous memory with two fully symmetric access ports driven from one clock. Each port has its own enable, write strobe, address, write data and a registered read-data output with a companion valid flag. Either port may read or write any word in any cycle. Read data appears on the port one clock after the enabled address is sampled.

Each port is built with one of three write behaviours, chosen by a parameter:
- **read-first**: the output shows the word's contents from before the write.
- **write-first**: the output shows the data being written.
- **no-change**: the output and its flag keep their earlier values.

When both ports land on the same word in the same cycle, the result follows the writer's behaviour. If the outcome is unreliable, the affected output's valid flag drops for that cycle, rather than the block relying on X propagation. If two writes to one word carry different data, the word is marked unreliable until a single clean write lands on it.

Top module: `twin_port_sram`

## Requirements
- R1: After reset both data outputs are zero and both valid flags are low.
- R2: A read returns the stored word on that port's output one cycle after the enabled address is sampled, with the valid flag high.
- R3: A read-first port that writes shows the word's previous contents on its output during that write.
- R4: A write-first port that writes shows its own write data on its output during that write.
- R5: A no-change port that writes keeps its output data and valid flag unchanged. A later read of the written word returns the new data.
- R6: With a port's enable low, its output data and flag hold, and its write strobe has no effect on memory.
- R7: Two same-cycle reads of one word both return the stored word with valid high.
- R8: When one port writes and the other reads the same word in one cycle with the writer in read-first mode, the write is stored and the reader shows the previous contents with valid high.
- R9: When the writer is in write-first or no-change mode in that collision, the reader's valid flag is low that cycle whatever its own mode, and the write is still stored.
- R10: Two same-cycle writes of identical data to one word store that data, and neither output is flagged invalid.
- R11: Two same-cycle writes of different data to one word mark it unreliable. During that cycle, a write-first port's flag is low and a read-first port's flag reflects the old word. Reads of the word, and read-first outputs of writes to it, report valid low until a write that is not a differing-data clash clears the mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rstN | input | 1 | Active-low synchronous reset of outputs and unreliable marks |
| enA | input | 1 | Port A access enable |
| weA | input | 1 | Port A write strobe |
| addrA | input | $clog2(DEPTH) | Port A word address |
| dinA | input | WIDTH | Port A write data |
| doutA | output | WIDTH | Port A registered read data |
| validA | output | 1 | Port A output trustworthy |
| enB | input | 1 | Port B access enable |
| weB | input | 1 | Port B write strobe |
| addrB | input | $clog2(DEPTH) | Port B word address |
| dinB | input | WIDTH | Port B write data |
| doutB | output | WIDTH | Port B registered read data |
| validB | output | 1 | Port B output trustworthy |

## Verification
A write on one port and an access on the other to the same word can fall in the same cycle. The bench provokes this by sweeping matched addresses on both ports, with every pairing of write and read strobes. Two builds run side by side, with differing write-behaviour pairs, so that each mode meets each role. Each cycle's outputs and flags are compared with a bench model of the memory contents and unreliable marks, built from the mode rules. Reads after each collision confirm what was stored.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

  typedef enum logic [1:0] {
    MODE_READ_FIRST  = 2'd0,
    MODE_WRITE_FIRST = 2'd1,
    MODE_NO_CHANGE   = 2'd2
  } writeMode_e;

  // Strobes from control to datapath, one set per port.
  typedef struct packed {
    logic memWrite;    // store din at addr
    logic poisonSet;   // mark the word unreliable
    logic poisonClear; // clean write clears the mark
    logic outLoad;     // update the output register
    logic outSelNew;   // load din instead of the stored word
    logic outValid;    // value for the valid flag
  } portStrobe_t;

  localparam int NUM_PORTS = 2;

endpackage

// File: rtl/twin_port_ctrl.sv
module twin_port_ctrl
  import twin_port_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter int         WIDTH  = 16,
  parameter writeMode_e MODE_A = MODE_READ_FIRST,
  parameter writeMode_e MODE_B = MODE_READ_FIRST
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        en,
  input  logic [NUM_PORTS-1:0]        we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]  din,
  input  logic [NUM_PORTS-1:0]        poisonAt,
  output portStrobe_t [NUM_PORTS-1:0] strobe
);

  logic sameAddr;
  logic wrClash;

  assign sameAddr = en[0] & en[1] & (addr[0] == addr[1]);
  assign wrClash  = sameAddr & we[0] & we[1] & (din[0] != din[1]);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam writeMode_e OWN_MODE   = (p == 0) ? MODE_A : MODE_B;
    localparam writeMode_e OTHER_MODE = (p == 0) ? MODE_B : MODE_A;
    localparam int         Q          = 1 - p;

    always_comb begin
      strobe[p]             = '0;
      strobe[p].memWrite    = en[p] & we[p];
      strobe[p].poisonSet   = en[p] & we[p] & wrClash;
      strobe[p].poisonClear = en[p] & we[p] & ~wrClash;
      if (en[p]) begin
        if (we[p]) begin
          unique case (OWN_MODE)
            MODE_READ_FIRST: begin
              strobe[p].outLoad  = 1'b1;
              strobe[p].outValid = ~poisonAt[p];
            end
            MODE_WRITE_FIRST: begin
              strobe[p].outLoad   = 1'b1;
              strobe[p].outSelNew = 1'b1;
              strobe[p].outValid  = ~wrClash;
            end
            default: strobe[p].outLoad = 1'b0;
          endcase
        end else begin
          strobe[p].outLoad  = 1'b1;
          strobe[p].outValid = ~(poisonAt[p] |
                                 (sameAddr & we[Q] & (OTHER_MODE != MODE_READ_FIRST)));
        end
      end
    end

    // A clash with differing data must never also clear the mark
    assert_clash_keeps_mark_R11: assert property (@(posedge clk) disable iff (!rstN)
      (wrClash && en[p] && we[p]) |-> (strobe[p].poisonSet && !strobe[p].poisonClear));
  end

endmodule

// File: rtl/twin_port_datapath.sv
module twin_port_datapath
  import twin_port_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]  din,
  input  portStrobe_t [NUM_PORTS-1:0] strobe,
  output logic [NUM_PORTS-1:0]        poisonAt,
  output logic [NUM_PORTS-1:0][WIDTH-1:0]  dout,
  output logic [NUM_PORTS-1:0]        valid
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] poison;

  // Port A is applied last, so it holds the word after a differing clash
  always_ff @(posedge clk) begin
    if (strobe[1].memWrite) mem[addr[1]] <= din[1];
    if (strobe[0].memWrite) mem[addr[0]] <= din[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      poison <= '0;
    end else begin
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (strobe[p].poisonSet)        poison[addr[p]] <= 1'b1;
        else if (strobe[p].poisonClear) poison[addr[p]] <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    assign poisonAt[p] = poison[addr[p]];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dout[p]  <= '0;
        valid[p] <= 1'b0;
      end else if (strobe[p].outLoad) begin
        dout[p]  <= strobe[p].outSelNew ? din[p] : mem[addr[p]];
        valid[p] <= strobe[p].outValid;
      end
    end

    // A differing clash leaves the word marked in the next cycle
    assert_mark_lands_R11: assert property (@(posedge clk) disable iff (!rstN)
      strobe[p].poisonSet |=> poison[$past(addr[p])]);
  end

endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram
  import twin_port_pkg::*;
#(
  parameter int         DEPTH  = 1024,
  parameter int         WIDTH  = 16,
  parameter writeMode_e MODE_A = MODE_READ_FIRST,
  parameter writeMode_e MODE_B = MODE_READ_FIRST
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enA,
  input  logic                     weA,
  input  logic [$clog2(DEPTH)-1:0] addrA,
  input  logic [WIDTH-1:0]         dinA,
  output logic [WIDTH-1:0]         doutA,
  output logic                     validA,
  input  logic                     enB,
  input  logic                     weB,
  input  logic [$clog2(DEPTH)-1:0] addrB,
  input  logic [WIDTH-1:0]         dinB,
  output logic [WIDTH-1:0]         doutB,
  output logic                     validB
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic [NUM_PORTS-1:0]              enVec, weVec, poisonAt, validVec;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addrVec;
  logic [NUM_PORTS-1:0][WIDTH-1:0]   dinVec, doutVec;
  portStrobe_t [NUM_PORTS-1:0]       strobe;

  assign enVec   = {enB, enA};
  assign weVec   = {weB, weA};
  assign addrVec = {addrB, addrA};
  assign dinVec  = {dinB, dinA};
  assign doutA   = doutVec[0];
  assign doutB   = doutVec[1];
  assign validA  = validVec[0];
  assign validB  = validVec[1];

  twin_port_ctrl #(
    .ADDR_W(ADDR_W), .WIDTH(WIDTH), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .en(enVec), .we(weVec), .addr(addrVec),
    .din(dinVec), .poisonAt(poisonAt), .strobe(strobe)
  );

  twin_port_datapath #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addrVec), .din(dinVec), .strobe(strobe),
    .poisonAt(poisonAt), .dout(doutVec), .valid(validVec)
  );

  assert_idle_hold_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enA |=> ($stable(doutA) && $stable(validA)));
  assert_idle_hold_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enB |=> ($stable(doutB) && $stable(validB)));

  if (MODE_A == MODE_WRITE_FIRST) begin : g_wf_a
    assert_write_shows_new_R4: assert property (@(posedge clk) disable iff (!rstN)
      (enA && weA) |=> (doutA == $past(dinA)));
  end
  if (MODE_A == MODE_NO_CHANGE) begin : g_nc_a
    assert_write_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
      (enA && weA) |=> ($stable(doutA) && $stable(validA)));
  end
  if (MODE_A == MODE_READ_FIRST) begin : g_rf_a
    assert_both_see_old_R8: assert property (@(posedge clk) disable iff (!rstN)
      (enA && weA && enB && !weB && addrA == addrB) |=> (doutA == doutB));
  end else begin : g_unsafe_a
    assert_reader_flagged_R9: assert property (@(posedge clk) disable iff (!rstN)
      (enA && weA && enB && !weB && addrA == addrB) |=> !validB);
  end
  if (MODE_B != MODE_READ_FIRST) begin : g_unsafe_b
    assert_reader_flagged_b_R9: assert property (@(posedge clk) disable iff (!rstN)
      (enB && weB && enA && !weA && addrA == addrB) |=> !validA);
  end

endmodule

// File: tb/sim_twin_port_sram.sv
module sim_twin_port_sram;
  import twin_port_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic enA = 0, weA = 0, enB = 0, weB = 0;
  logic [3:0] addrA = '0, addrB = '0;
  logic [7:0] dinA = '0, dinB = '0;
  logic [7:0] doA0, doB0, doA1, doB1;
  logic vA0, vB0, vA1, vB1;

  twin_port_sram #(.DEPTH(DEPTH), .WIDTH(WIDTH),
    .MODE_A(MODE_READ_FIRST), .MODE_B(MODE_WRITE_FIRST)) u0 (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA),
    .doutA(doA0), .validA(vA0), .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB),
    .doutB(doB0), .validB(vB0));

  twin_port_sram #(.DEPTH(DEPTH), .WIDTH(WIDTH),
    .MODE_A(MODE_NO_CHANGE), .MODE_B(MODE_READ_FIRST)) u1 (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA),
    .doutA(doA1), .validA(vA1), .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB),
    .doutB(doB1), .validB(vB1));

  int checks = 0;
  int errors = 0;
  logic [7:0] refMem [2][DEPTH];
  bit         refPoi [2][DEPTH];
  logic [7:0] expDo  [2][2];
  bit         expVal [2][2];
  writeMode_e md     [2][2];

  function automatic logic [8:0] got(int i, int p);
    if (i == 0) return (p == 0) ? {vA0, doA0} : {vB0, doB0};
    return (p == 0) ? {vA1, doA1} : {vB1, doB1};
  endfunction

  task automatic checkOut(string tag, int i, int p);
    logic [8:0] g = got(i, p);
    checks++;
    if (g[8] !== expVal[i][p]) begin
      errors++;
      $display("FAIL %s u%0d port%0d valid: actual=%b expected=%b", tag, i, p, g[8], expVal[i][p]);
    end
    if (expVal[i][p] && !$isunknown(expDo[i][p])) begin
      checks++;
      if (g[7:0] !== expDo[i][p]) begin
        errors++;
        $display("FAIL %s u%0d port%0d data: actual=%h expected=%h", tag, i, p, g[7:0], expDo[i][p]);
      end
    end
  endtask

  task automatic step(string tag, logic e0, logic w0, logic [3:0] a0, logic [7:0] d0,
                      logic e1, logic w1, logic [3:0] a1, logic [7:0] d1);
    logic e [2];
    logic w [2];
    logic [3:0] a [2];
    logic [7:0] d [2];
    e[0] = e0; e[1] = e1; w[0] = w0; w[1] = w1;
    a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    enA = e0; weA = w0; addrA = a0; dinA = d0;
    enB = e1; weB = w1; addrB = a1; dinB = d1;
    for (int i = 0; i < 2; i++) begin
      bit hit = e0 && e1 && (a0 == a1);
      bit wc = hit && w0 && w1 && (d0 != d1);
      for (int p = 0; p < 2; p++) begin
        int q = 1 - p;
        if (e[p]) begin
          if (w[p]) begin
            if (md[i][p] == MODE_READ_FIRST) begin
              expDo[i][p] = refMem[i][a[p]]; expVal[i][p] = !refPoi[i][a[p]];
            end else if (md[i][p] == MODE_WRITE_FIRST) begin
              expDo[i][p] = d[p]; expVal[i][p] = !wc;
            end
          end else begin
            expDo[i][p] = refMem[i][a[p]];
            expVal[i][p] = !(refPoi[i][a[p]] || (hit && w[q] && md[i][q] != MODE_READ_FIRST));
          end
        end
      end
      for (int p = 1; p >= 0; p--) begin
        if (e[p] && w[p]) begin
          refMem[i][a[p]] = d[p];
          refPoi[i][a[p]] = wc;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++) checkOut(tag, i, p);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    md[0][0] = MODE_READ_FIRST; md[0][1] = MODE_WRITE_FIRST;
    md[1][0] = MODE_NO_CHANGE;  md[1][1] = MODE_READ_FIRST;
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < DEPTH; k++) begin refMem[i][k] = 'x; refPoi[i][k] = 0; end
      for (int p = 0; p < 2; p++) begin expDo[i][p] = '0; expVal[i][p] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 2; p++) checkOut("R1", i, p);

    // Two fill passes: the second exercises each port's write behaviour on known data
    for (int k = 0; k < 8; k++)
      step("R3 R4 R5 fill", 1, 1, 4'(k), 8'(k * 29 + 7), 1, 1, 4'(k + 8), 8'(k * 53 + 101));
    for (int k = 0; k < 8; k++)
      step("R3 R4 R5", 1, 1, 4'(k + 8), 8'(k * 17 + 200), 1, 1, 4'(k), 8'(k * 91 + 13));
    for (int k = 0; k < DEPTH; k++)
      step("R2", 1, 0, 4'(k), 8'h00, 1, 0, 4'(15 - k), 8'h00);

    // Disabled ports: write strobe ignored, outputs hold
    step("R6", 0, 1, 4'd3, 8'hAA, 0, 1, 4'd9, 8'hBB);
    step("R6", 0, 0, 4'd5, 8'h00, 0, 0, 4'd6, 8'h00);
    step("R6", 1, 0, 4'd3, 8'h00, 1, 0, 4'd9, 8'h00);

    for (int k = 0; k < DEPTH; k++)
      step("R7", 1, 0, 4'(k), 8'h00, 1, 0, 4'(k), 8'h00);

    // Write against read on one word, each port in each role
    for (int k = 0; k < 4; k++)
      step("R8 R9", 1, 1, 4'(k), 8'(k + 8'hC0), 1, 0, 4'(k), 8'h00);
    for (int k = 4; k < 8; k++)
      step("R8 R9", 1, 0, 4'(k), 8'h00, 1, 1, 4'(k), 8'(k + 8'hD0));
    for (int k = 0; k < 8; k++)
      step("R8 R9 readback", 1, 0, 4'(k), 8'h00, 1, 0, 4'(k), 8'h00);

    for (int k = 8; k < 12; k++)
      step("R10", 1, 1, 4'(k), 8'(k * 3), 1, 1, 4'(k), 8'(k * 3));
    for (int k = 8; k < 12; k++)
      step("R10 readback", 1, 0, 4'(k), 8'h00, 1, 0, 4'(k), 8'h00);

    step("R11", 1, 1, 4'd12, 8'h11, 1, 1, 4'd12, 8'h22);
    step("R11", 1, 0, 4'd12, 8'h00, 1, 0, 4'd12, 8'h00);
    step("R11", 1, 1, 4'd12, 8'h33, 0, 0, 4'd0, 8'h00);
    step("R11", 1, 0, 4'd12, 8'h00, 1, 0, 4'd12, 8'h00);
    step("R11", 1, 1, 4'd13, 8'h55, 1, 1, 4'd13, 8'h66);
    step("R11", 1, 1, 4'd13, 8'h44, 0, 0, 4'd0, 8'h00);
    step("R11", 0, 0, 4'd0, 8'h00, 1, 1, 4'd13, 8'h77);
    step("R11 R5", 1, 0, 4'd13, 8'h00, 1, 0, 4'd13, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule